// File: doc/BRIEF.md
# Four-Channel Programmable Trigger Delay Generator

This block takes one shared trigger line and produces four delayed output pulses, one per channel. Each channel has its own coarse delay (in system clock ticks), its own pulse width (in ticks) and its own enable. The trigger is passed through a two-flop synchronizer. A rising level counts as a trigger only after it has been seen high for three consecutive clock samples, so shorter glitches are dropped. When a trigger is accepted, every enabled channel latches its configuration. It counts down its delay, drives a pulse of the programmed width, and then returns to idle.

After an acceptance the block is locked. It ignores further triggers until the longest delay among the enabled channels has run out. Every delay is measured from the first clock edge that sampled the trigger high. The fixed latency of the synchronizer and qualifier is subtracted inside the block, so a programmed delay of D ticks gives a rising output exactly D edges after that first sample.

The trigger front end has two states. ARMED moves to SEEN when three high samples are seen (this is an acceptance if the block is unlocked), and SEEN returns to ARMED when the synchronized input is low. Each channel has three states. IDLE moves to WAIT on an acceptance with the channel enabled. WAIT moves to PULSE when the delay count is exhausted, and PULSE moves to IDLE when the width count is exhausted. An acceptance reloads WAIT or PULSE, and an acceptance with the channel disabled returns it to IDLE. The lockout has two states. READY moves to HOLD on an acceptance with any channel enabled, and HOLD moves back to READY when the longest delay count ends.

Top module: `trig_delay_gen`

## Requirements
- R1: After reset, `pulse_out`, `chan_busy` and `locked` are all 0.
- R2: A trigger that is high for only 1 or 2 consecutive clock samples produces no output pulse and does not set `locked`.
- R3: If `trig_in` is first sampled high at edge E0 and stays high for at least 3 samples, then each enabled channel i raises `pulse_out[i]` just after edge E0+D, where D is its effective delay.
- R4: The pulse lasts W clock cycles, where W is the channel's 16-bit `ch_width` field (channel i uses bits [16i+15:16i]). A width of 0 gives a 1-cycle pulse.
- R5: A delay field below 63 is treated as 63. The delay field for channel i is bits [34i+33:34i] of `ch_delay`.
- R6: A channel whose `ch_enable` bit is 0 at acceptance never pulses, and its `chan_busy` stays 0.
- R7: `locked` is high from just after edge E0+4 until edge E0+Dmax, where Dmax is the largest effective delay among the enabled channels. A trigger whose third high sample is at or before edge E0+Dmax-2 is ignored. A trigger whose third high sample is at edge E0+Dmax-1 or later is accepted. With no channel enabled, `locked` stays 0.
- R8: Configuration is captured at acceptance. Changing it while a channel is busy does not alter that channel's pending pulse.
- R9: A trigger held high for a long time is accepted only once. A new trigger needs the input to go low first.
- R10: `chan_busy[i]` is high from just after edge E0+4 until the pulse ends. That is D+W-4 cycles for effective delay D and effective width W. An acceptance that arrives during a channel's pulse restarts that channel's delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous shared trigger |
| ch_enable | input | 4 | Per-channel enable, bit i for channel i |
| ch_delay | input | 136 | Per-channel delay in ticks, 34 bits each |
| ch_width | input | 64 | Per-channel pulse width in ticks, 16 bits each |
| pulse_out | output | 4 | Registered delayed pulses |
| chan_busy | output | 4 | Channel waiting or pulsing |
| locked | output | 1 | New triggers are being ignored |

## Verification
The assertions assume that `trig_in` is a clean digital level that may change at any time. They also assume that configuration inputs are stable in the cycle of acceptance. They do not assume any particular delay value, because clamping keeps every count above the pipeline latency. The stimulus drives the trigger only between clock edges, holds it for exact sample counts, and changes configuration only at falling edges. It also keeps output widths short where a second trigger follows close behind, so that a restarted channel's pulse width stays predictable.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_PULSE} ch_state_t;
    typedef enum logic {LK_READY, LK_HOLD} lock_state_t;
    typedef enum logic {FR_ARMED, FR_SEEN} front_state_t;
endpackage

// File: rtl/tdg_front.sv
module tdg_front #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic locked,
    output logic accept
);
    import tdg_pkg::*;
    localparam int DEPTH = SYNC_STAGES + QUAL_SAMPLES - 1;

    logic [DEPTH-1:0] shr;
    logic             qual;
    logic             level;
    front_state_t     st, nst;

    always_ff @(posedge clk) begin
        if (!rst_n) shr <= '0;
        else        shr <= {shr[DEPTH-2:0], trig_in};
    end

    assign qual  = &shr[DEPTH-1:SYNC_STAGES-1];
    assign level = shr[SYNC_STAGES-1];

    always_comb begin
        nst = st;
        unique case (st)
            FR_ARMED: if (qual)   nst = FR_SEEN;
            FR_SEEN:  if (!level) nst = FR_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= FR_ARMED;
        else        st <= nst;
    end

    assign accept = (st == FR_ARMED) && qual && !locked;

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R9
endmodule

// File: rtl/tdg_channel.sv
module tdg_channel #(
    parameter int DLY_W = 34,
    parameter int WID_W = 16,
    parameter int LAT   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic [DLY_W-1:0] eff_dly,
    input  logic [WID_W-1:0] width,
    output logic             pulse,
    output logic             busy
);
    import tdg_pkg::*;

    ch_state_t        st, nst;
    logic [DLY_W-1:0] dcnt;
    logic [WID_W-1:0] wcnt;
    logic [WID_W-1:0] wid_l;

    always_comb begin
        nst = st;
        unique case (st)
            CH_IDLE:  if (load && en) nst = CH_WAIT;
            CH_WAIT:  if (load)       nst = en ? CH_WAIT : CH_IDLE;
                      else if (dcnt == '0) nst = CH_PULSE;
            CH_PULSE: if (load)       nst = en ? CH_WAIT : CH_IDLE;
                      else if (wcnt == '0) nst = CH_IDLE;
            default:  nst = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CH_IDLE;
            dcnt  <= '0;
            wcnt  <= '0;
            wid_l <= '0;
        end else begin
            st <= nst;
            if (load && en) begin
                dcnt  <= eff_dly - DLY_W'(LAT);
                wid_l <= width;
            end else if (st == CH_WAIT) begin
                if (dcnt == '0) wcnt <= (wid_l == '0) ? '0 : wid_l - WID_W'(1);
                else            dcnt <= dcnt - DLY_W'(1);
            end else if (st == CH_PULSE && wcnt != '0) begin
                wcnt <= wcnt - WID_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            busy  <= 1'b0;
        end else begin
            pulse <= (nst == CH_PULSE);
            busy  <= (nst != CH_IDLE);
        end
    end

    AST_RISE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(st == CH_WAIT)); // R3
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> busy); // R10
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !en) |=> !pulse); // R6
endmodule

// File: rtl/tdg_lockout.sv
module tdg_lockout #(
    parameter int N_CH  = 4,
    parameter int DLY_W = 34,
    parameter int LAT   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [N_CH-1:0]       en,
    input  logic [N_CH*DLY_W-1:0] eff_dly,
    output logic                  locked
);
    import tdg_pkg::*;

    lock_state_t      st, nst;
    logic [DLY_W-1:0] longest;
    logic [DLY_W-1:0] cnt;

    always_comb begin
        longest = '0;
        for (int i = 0; i < N_CH; i++)
            if (en[i] && eff_dly[i*DLY_W +: DLY_W] > longest)
                longest = eff_dly[i*DLY_W +: DLY_W];
    end

    always_comb begin
        nst = st;
        unique case (st)
            LK_READY: if (load && |en) nst = LK_HOLD;
            LK_HOLD:  if (cnt == '0)   nst = LK_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LK_READY;
            cnt <= '0;
        end else begin
            st <= nst;
            if (st == LK_READY && load && |en) cnt <= longest - DLY_W'(LAT);
            else if (st == LK_HOLD && cnt != '0) cnt <= cnt - DLY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) locked <= 1'b0;
        else        locked <= (nst == LK_HOLD);
    end

    AST_LOCK_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(load)); // R7
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
    parameter int N_CH         = 4,
    parameter int DLY_W        = 34,
    parameter int WID_W        = 16,
    parameter int MIN_DLY      = 63,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_in,
    input  logic [N_CH-1:0]       ch_enable,
    input  logic [N_CH*DLY_W-1:0] ch_delay,
    input  logic [N_CH*WID_W-1:0] ch_width,
    output logic [N_CH-1:0]       pulse_out,
    output logic [N_CH-1:0]       chan_busy,
    output logic                  locked
);
    localparam int LAT = SYNC_STAGES + QUAL_SAMPLES;

    logic                  accept;
    logic [N_CH*DLY_W-1:0] eff_dly;

    tdg_front #(.SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES)) u_front (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .locked(locked), .accept(accept)
    );

    tdg_lockout #(.N_CH(N_CH), .DLY_W(DLY_W), .LAT(LAT)) u_lock (
        .clk(clk), .rst_n(rst_n), .load(accept), .en(ch_enable),
        .eff_dly(eff_dly), .locked(locked)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign eff_dly[i*DLY_W +: DLY_W] =
            (ch_delay[i*DLY_W +: DLY_W] < DLY_W'(MIN_DLY)) ? DLY_W'(MIN_DLY)
                                                          : ch_delay[i*DLY_W +: DLY_W];

        tdg_channel #(.DLY_W(DLY_W), .WID_W(WID_W), .LAT(LAT)) u_ch (
            .clk(clk), .rst_n(rst_n), .load(accept), .en(ch_enable[i]),
            .eff_dly(eff_dly[i*DLY_W +: DLY_W]), .width(ch_width[i*WID_W +: WID_W]),
            .pulse(pulse_out[i]), .busy(chan_busy[i])
        );

        AST_PULSE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_out[i]) |-> $past(locked)); // R7
    end
endmodule

// File: tb/test_trig_delay_gen.sv
module test_trig_delay_gen;
    localparam int NC = 4;
    localparam int DW = 34;
    localparam int WW = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic trig_in = 0;
    logic [NC-1:0] ch_enable = '0;
    logic [DW-1:0] dly [NC];
    logic [WW-1:0] wid [NC];
    logic [NC*DW-1:0] ch_delay;
    logic [NC*WW-1:0] ch_width;
    logic [NC-1:0] pulse_out, chan_busy;
    logic locked;

    int checks = 0, errors = 0, cyc = 0;
    int rises[NC], rise_at[NC], hi[NC], bz[NC];
    logic prev[NC];
    int lk, lk_at;
    logic lkprev;
    bit mon_on = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb
        for (int c = 0; c < NC; c++) begin
            ch_delay[c*DW +: DW] = dly[c];
            ch_width[c*WW +: WW] = wid[c];
        end

    trig_delay_gen i_trig_delay_gen (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ch_enable(ch_enable),
        .ch_delay(ch_delay), .ch_width(ch_width), .pulse_out(pulse_out),
        .chan_busy(chan_busy), .locked(locked)
    );

    always @(negedge clk) if (mon_on) begin
        for (int c = 0; c < NC; c++) begin
            if (pulse_out[c]) hi[c]++;
            if (pulse_out[c] && !prev[c]) begin rises[c]++; rise_at[c] = cyc; end
            prev[c] = pulse_out[c];
            if (chan_busy[c]) bz[c]++;
        end
        if (locked) lk++;
        if (locked && !lkprev) lk_at = cyc;
        lkprev = locked;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            rises[c] = 0; rise_at[c] = 0; hi[c] = 0; bz[c] = 0; prev[c] = 0;
        end
        lk = 0; lk_at = 0; lkprev = 0; mon_on = 1;
    endtask

    task automatic fire(int len, output int e0);
        @(negedge clk);
        trig_in = 1;
        e0 = cyc + 1;
        repeat (len) @(posedge clk);
        @(negedge clk);
        trig_in = 0;
    endtask

    function automatic int effd(int d); return (d < 63) ? 63 : d; endfunction
    function automatic int effw(int w); return (w == 0) ? 1 : w; endfunction

    task automatic sweep(int mask);
        int e0, dmax;
        @(negedge clk);
        ch_enable = mask[NC-1:0];
        dmax = 0;
        for (int c = 0; c < NC; c++) begin
            dly[c] = DW'((mask * 13 + c * 29) % 140);
            wid[c] = WW'((mask + c) % 5);
            if (mask[c] && effd(int'(dly[c])) > dmax) dmax = effd(int'(dly[c]));
        end
        mon_clear();
        fire(3, e0);
        repeat (160) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            int d = effd(int'(dly[c]));
            int w = effw(int'(wid[c]));
            if (mask[c]) begin
                check(rise_at[c] == e0 + d, (dly[c] < 63) ? "R5 clamp" : "R3 rise",
                      rise_at[c] - e0, d);
                check(hi[c] == w, "R4 width", hi[c], w);
                check(bz[c] == d + w - 4, "R10 busy", bz[c], d + w - 4);
            end else begin
                check(rises[c] == 0 && bz[c] == 0, "R6 disabled", rises[c] + bz[c], 0);
            end
        end
        if (mask != 0) begin
            check(lk == dmax - 4, "R7 lock length", lk, dmax - 4);
            check(lk_at == e0 + 4, "R7 lock start", lk_at - e0, 4);
        end else begin
            check(lk == 0, "R7 no lock", lk, 0);
        end
        mon_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e0, e1, sum;
        for (int c = 0; c < NC; c++) begin dly[c] = '0; wid[c] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        check(pulse_out == 0 && chan_busy == 0 && locked == 0, "R1 reset",
              int'({pulse_out, chan_busy, locked}), 0);

        for (int m = 0; m < 16; m++) sweep(m);

        // R2 glitch rejection
        for (int len = 1; len <= 2; len++) begin
            @(negedge clk);
            ch_enable = '1;
            for (int c = 0; c < NC; c++) begin dly[c] = 70; wid[c] = 2; end
            mon_clear();
            fire(len, e0);
            repeat (100) @(posedge clk);
            @(negedge clk);
            sum = rises[0] + rises[1] + rises[2] + rises[3] + lk;
            check(sum == 0, "R2 glitch", sum, 0);
            mon_on = 0;
        end

        // R9 held level accepted once
        mon_clear();
        fire(200, e0);
        repeat (50) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) check(rises[c] == 1, "R9 held", rises[c], 1);
        mon_on = 0;

        // R7 boundary: ignored then accepted retrigger
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            ch_enable = 4'b0001;
            dly[0] = 100; wid[0] = 1;
            mon_clear();
            fire(3, e0);
            while (cyc < e0 + 94 + k) @(negedge clk);
            fire(3, e1);
            repeat (150) @(posedge clk);
            @(negedge clk);
            check(e1 == e0 + 96 + k, "R7 stimulus", e1 - e0, 96 + k);
            check(rises[0] == 1 + k, "R7 retrigger", rises[0], 1 + k);
            if (k == 1) check(rise_at[0] == e1 + 100, "R7 second rise", rise_at[0] - e1, 100);
            mon_on = 0;
        end

        // R8 configuration captured at acceptance
        @(negedge clk);
        ch_enable = '1;
        for (int c = 0; c < NC; c++) begin dly[c] = 80; wid[c] = 3; end
        mon_clear();
        fire(3, e0);
        while (cyc < e0 + 20) @(negedge clk);
        ch_enable = '0;
        for (int c = 0; c < NC; c++) begin dly[c] = 200; wid[c] = 9; end
        repeat (120) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            check(rise_at[c] == e0 + 80, "R8 delay kept", rise_at[c] - e0, 80);
            check(hi[c] == 3, "R8 width kept", hi[c], 3);
        end
        mon_on = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule